// File: doc/BRIEF.md
# Commit-time rename tag checker

This block watches the register renaming of an out-of-order core and flags corrupted destination tags. It keeps its own copy of the architectural-to-physical mapping. That copy changes only when an instruction retires. When an instruction is renamed, the block takes the destination's architectural index, the newly allocated physical register and the physical register that mapping replaced, and stores them in a small in-order tag store that mirrors the reorder buffer. When the oldest entry retires, the commit copy of the mapping must still name the replaced physical register. If it does not, a tag was corrupted somewhere between rename and commit.

Each physical register also carries a ready bit and a free bit. A register that is being written back must be allocated and not yet written, so both bits must be clear at that moment. Only destination tags are covered; source-operand tags are not examined. The error output is a one-cycle pulse with a two-bit cause. The block does not repair anything: a flush only discards the in-flight entries.

Top module: `rename_tag_checker`

## Requirements
- R1: After reset the commit map sends architectural register i to physical register i. Physical registers below the architectural count have ready=1 and free=0. All others have ready=0 and free=1. The tag store is empty and err_valid is 0.
- R2: An accepted rename (ren_valid=1, flush=0, tag store not full) appends {ren_arch, ren_new_phys, ren_prev_phys} to the tag store and clears both status bits of ren_new_phys. A rename while the store holds ROB_DEPTH entries is ignored.
- R3: An accepted retire (ret_valid=1, flush=0, store not empty) compares the commit map entry of the oldest entry's architectural register with its saved previous physical register. A difference raises code 2'b01. In either case the commit map entry then takes the entry's new physical register.
- R4: An accepted retire sets the free bit and clears the ready bit of the saved previous physical register.
- R5: A writeback (wb_valid=1) whose register has its free bit set raises code 2'b11. Otherwise, if its ready bit is set, it raises code 2'b10. Otherwise it sets the ready bit. A writeback that raises an error leaves both bits unchanged.
- R6: err_valid is 1 for exactly the cycle after a cycle that raised an error, and err_code then holds the cause. Otherwise err_valid is 0 and err_code is 2'b00. When a mapping mismatch and a writeback error occur in the same cycle, code 2'b01 is reported.
- R7: flush=1 empties the tag store and leaves the commit map and the status bits unchanged. A rename or retire in the same cycle is ignored. A writeback in that cycle is still checked.
- R8: A retire while the tag store is empty is ignored: no error and no state change.
- R9: Retirement is in order, at most one entry per cycle. A rename and a retire can be accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Discard all in-flight entries |
| ren_valid | input | 1 | Rename of one destination this cycle |
| ren_arch | input | 5 | Architectural destination index |
| ren_new_phys | input | 6 | Physical register newly allocated |
| ren_prev_phys | input | 6 | Physical register the destination mapped to before |
| wb_valid | input | 1 | Result written back this cycle |
| wb_phys | input | 6 | Physical register being written |
| ret_valid | input | 1 | Retire the oldest entry |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 01 mapping mismatch, 10 ready set at writeback, 11 free set at writeback |

## Verification
Every error is registered once. The pulse for a rename, retire or writeback decision therefore appears one clock after the cycle in which that request was presented. Inputs are driven at the falling edge. The error output is sampled one nanosecond after the next rising edge, so each check lines up with the cycle that caused it. State that the ports do not show, such as status bits, map contents and tag store occupancy, is read back later by further writebacks and retires, whose error or silence is due in the same one-cycle slot. A bench-side model built from the requirements predicts the outcome of every cycle, and the output is compared against it on every cycle, including idle ones.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_MAP   = 2'b01,
    ERR_READY = 2'b10,
    ERR_FREE  = 2'b11
  } rtc_err_e;
endpackage

// File: rtl/rtc_commit_map.sv
module rtc_commit_map #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_arch,
  output logic [PW-1:0] rd_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys
);

  logic [PW-1:0] map_ent [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    logic          ent_we;
    logic [PW-1:0] ent_q;

    assign ent_we = wr_en && (wr_arch == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= PW'(g);
      end else if (ent_we) begin
        ent_q <= wr_phys;
      end
    end

    assign map_ent[g] = ent_q;
  end

  assign rd_phys = map_ent[rd_arch];

  AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_ent[$past(wr_arch)] == $past(wr_phys)); // R3

endmodule

// File: rtl/rtc_rob_store.sv
module rtc_rob_store #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int PW    = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_arch,
  input  logic [PW-1:0] push_new,
  input  logic [PW-1:0] push_prev,
  input  logic          pop,
  output logic [AW-1:0] head_arch,
  output logic [PW-1:0] head_new,
  output logic [PW-1:0] head_prev,
  output logic          empty,
  output logic          full
);

  logic [AW-1:0]    arch_mem [DEPTH];
  logic [PW-1:0]    new_mem  [DEPTH];
  logic [PW-1:0]    prev_mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) tail_d = bump(tail_q);
      if (pop)  head_d = bump(head_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      arch_mem[tail_q] <= push_arch;
      new_mem[tail_q]  <= push_new;
      prev_mem[tail_q] <= push_prev;
    end
  end

  assign head_arch = arch_mem[head_q];
  assign head_new  = new_mem[head_q];
  assign head_prev = prev_mem[head_q];

  AST_ROB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R2
  AST_ROB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_ROB_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R7

endmodule

// File: rtl/rtc_phys_status.sv
module rtc_phys_status #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_ARCH = 32,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [PW-1:0] alloc_phys,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_phys,
  input  logic          wb_en,
  input  logic [PW-1:0] wb_phys,
  output logic          wb_ready_hit,
  output logic          wb_free_hit
);

  logic [NUM_PHYS-1:0] ready_vec;
  logic [NUM_PHYS-1:0] free_vec;
  logic                wb_set;

  assign wb_ready_hit = wb_en && ready_vec[wb_phys];
  assign wb_free_hit  = wb_en && free_vec[wb_phys];
  assign wb_set       = wb_en && !ready_vec[wb_phys] && !free_vec[wb_phys];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
    localparam logic MAPPED = (g < NUM_ARCH);
    logic rdy_q, rdy_d, fre_q, fre_d, bit_en;

    always_comb begin
      rdy_d = rdy_q;
      fre_d = fre_q;
      if (rel_en && rel_phys == PW'(g)) begin
        fre_d = 1'b1;
        rdy_d = 1'b0;
      end
      if (alloc_en && alloc_phys == PW'(g)) begin
        fre_d = 1'b0;
        rdy_d = 1'b0;
      end
      if (wb_set && wb_phys == PW'(g)) begin
        rdy_d = 1'b1;
      end
    end

    assign bit_en = (rdy_d != rdy_q) || (fre_d != fre_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q <= MAPPED;
        fre_q <= !MAPPED;
      end else if (bit_en) begin
        rdy_q <= rdy_d;
        fre_q <= fre_d;
      end
    end

    assign ready_vec[g] = rdy_q;
    assign free_vec[g]  = fre_q;
  end

  AST_WB_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_set |=> ready_vec[$past(wb_phys)]); // R5
  AST_REL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !(alloc_en && alloc_phys == rel_phys) && !(wb_set && wb_phys == rel_phys))
    |=> (free_vec[$past(rel_phys)] && !ready_vec[$past(rel_phys)])); // R4
  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !(wb_set && wb_phys == alloc_phys)) |=> !free_vec[$past(alloc_phys)]); // R2

endmodule

// File: rtl/rename_tag_checker.sv
module rename_tag_checker
  import rtc_pkg::*;
#(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_PHYS  = 64,
  parameter int ROB_DEPTH = 32,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  input  logic [PW-1:0] ren_new_phys,
  input  logic [PW-1:0] ren_prev_phys,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_phys,
  input  logic          ret_valid,
  output logic          err_valid,
  output logic [1:0]    err_code
);

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          rob_empty, rob_full;
  logic [AW-1:0] head_arch;
  logic [PW-1:0] head_new, head_prev, map_rd_phys;
  logic          ren_fire, ret_fire, map_mismatch;
  logic          wb_ready_hit, wb_free_hit;
  logic          err_valid_d, err_valid_q;
  rtc_err_e      err_code_d, err_code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign ren_fire = ren_valid && !flush && !rob_full;
  assign ret_fire = ret_valid && !flush && !rob_empty;

  rtc_rob_store #(.DEPTH(ROB_DEPTH), .AW(AW), .PW(PW)) u_rob (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flush     (flush),
    .push      (ren_fire),
    .push_arch (ren_arch),
    .push_new  (ren_new_phys),
    .push_prev (ren_prev_phys),
    .pop       (ret_fire),
    .head_arch (head_arch),
    .head_new  (head_new),
    .head_prev (head_prev),
    .empty     (rob_empty),
    .full      (rob_full)
  );

  rtc_commit_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_arch (head_arch),
    .rd_phys (map_rd_phys),
    .wr_en   (ret_fire),
    .wr_arch (head_arch),
    .wr_phys (head_new)
  );

  rtc_phys_status #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_status (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .alloc_en     (ren_fire),
    .alloc_phys   (ren_new_phys),
    .rel_en       (ret_fire),
    .rel_phys     (head_prev),
    .wb_en        (wb_valid),
    .wb_phys      (wb_phys),
    .wb_ready_hit (wb_ready_hit),
    .wb_free_hit  (wb_free_hit)
  );

  assign map_mismatch = ret_fire && (map_rd_phys != head_prev);

  always_comb begin
    err_valid_d = 1'b1;
    if (map_mismatch)      err_code_d = ERR_MAP;
    else if (wb_free_hit)  err_code_d = ERR_FREE;
    else if (wb_ready_hit) err_code_d = ERR_READY;
    else begin
      err_code_d  = ERR_NONE;
      err_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      err_valid_q <= 1'b0;
      err_code_q  <= ERR_NONE;
    end else begin
      err_valid_q <= err_valid_d;
      err_code_q  <= err_code_d;
    end
  end

  assign err_valid = err_valid_q;
  assign err_code  = err_code_q;

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    err_valid |-> (err_code != 2'b00)); // R6
  AST_MISMATCH_REPORTED: assert property (@(posedge clk) disable iff (!rst_core_n)
    map_mismatch |=> (err_valid && err_code == 2'b01)); // R3
  AST_FLUSH_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_core_n)
    flush |=> !(err_valid && err_code == 2'b01)); // R7

endmodule

// File: tb/rename_tag_checker_bench.sv
`timescale 1ns/1ps
module rename_tag_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       flush, ren_valid, wb_valid, ret_valid;
  logic [4:0] ren_arch;
  logic [5:0] ren_new_phys, ren_prev_phys, wb_phys;
  logic       err_valid;
  logic [1:0] err_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_map  [32];
  bit m_rdy  [64];
  bit m_free [64];
  int q_arch [32];
  int q_new  [32];
  int q_prev [32];
  int q_head = 0, q_tail = 0, q_cnt = 0;

  always #2.5 clk = ~clk;

  rename_tag_checker u_rename_tag_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_new_phys(ren_new_phys), .ren_prev_phys(ren_prev_phys),
    .wb_valid(wb_valid), .wb_phys(wb_phys), .ret_valid(ret_valid),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {err_valid,err_code} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit rv, input int ra, input int rn, input int rp,
                      input bit wv, input int wp, input bit tv, input bit fl);
    bit ret_ok, ren_ok, mm;
    int hp, code;
    @(negedge clk);
    ren_valid = rv; ren_arch = 5'(ra); ren_new_phys = 6'(rn); ren_prev_phys = 6'(rp);
    wb_valid = wv; wb_phys = 6'(wp); ret_valid = tv; flush = fl;
    ret_ok = tv && !fl && q_cnt > 0;
    ren_ok = rv && !fl && q_cnt < 32;
    hp = q_prev[q_head];
    mm = ret_ok && (m_map[q_arch[q_head]] != hp);
    code = 0;
    if (wv) code = m_free[wp] ? 3 : (m_rdy[wp] ? 2 : 0);
    if (wv && code == 0) m_rdy[wp] = 1;
    if (mm) code = 1;
    if (ret_ok) begin
      m_map[q_arch[q_head]] = q_new[q_head];
      m_free[hp] = 1; m_rdy[hp] = 0;
      q_head = (q_head + 1) % 32; q_cnt--;
    end
    if (ren_ok) begin
      q_arch[q_tail] = ra; q_new[q_tail] = rn; q_prev[q_tail] = rp;
      m_free[rn] = 0; m_rdy[rn] = 0;
      q_tail = (q_tail + 1) % 32; q_cnt++;
    end
    if (wv && code == 0 && !(ren_ok && rn == wp)) m_rdy[wp] = 1;
    if (fl) begin q_head = 0; q_tail = 0; q_cnt = 0; end
    @(posedge clk); #1;
    check(req, {err_valid, err_code}, {code != 0, 2'(code)});
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_map[i] = i;
    for (int i = 0; i < 64; i++) begin m_rdy[i] = (i < 32); m_free[i] = (i >= 32); end
    rst_n = 0; flush = 0; ren_valid = 0; wb_valid = 0; ret_valid = 0;
    ren_arch = 0; ren_new_phys = 0; ren_prev_phys = 0; wb_phys = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1 check("R1 reset", {err_valid, err_code}, 3'b000);

    // R1: reset status bits seen through writeback
    step("R1 free at reset", 0, 0, 0, 0, 1, 45, 0, 0);
    step("R1 ready at reset", 0, 0, 0, 0, 1, 7, 0, 0);
    idle("R6 pulse ends");

    // R2: fill the tag store, then a rename while full is dropped
    for (int a = 0; a < 32; a++) step("R2 rename", 1, a, 32 + a, a, 0, 0, 0, 0);
    step("R2 full", 1, 0, 40, 17, 0, 0, 0, 0);
    for (int a = 0; a < 32; a++) step("R5 clean wb", 0, 0, 0, 0, 1, 32 + a, 0, 0);
    step("R5 double wb", 0, 0, 0, 0, 1, 33, 0, 0);
    for (int a = 0; a < 32; a++) step("R3 R9 retire", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R8 empty retire", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R4 prev freed", 0, 0, 0, 0, 1, 5, 0, 0);

    // R9: rename, writeback and retire overlapped every cycle
    for (int a = 0; a <= 32; a++)
      step("R9 overlap", a < 32, a % 32, a % 32, 32 + (a % 32), a > 0, (a + 63) % 64, a > 0, 0);
    step("R4 released", 0, 0, 0, 0, 1, 40, 0, 0);

    // R3: corrupted previous tag, then map follows the retired mapping
    step("R3 bad rename", 1, 3, 40, 9, 0, 0, 0, 0);
    step("R3 mismatch", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R3 good rename", 1, 3, 41, 40, 0, 0, 0, 0);
    step("R3 map updated", 0, 0, 0, 0, 0, 0, 1, 0);

    // R6: mismatch outranks writeback error
    step("R6 bad rename", 1, 4, 42, 11, 0, 0, 0, 0);
    step("R6 priority", 0, 0, 0, 0, 1, 44, 1, 0);
    step("R5 free wb", 0, 0, 0, 0, 1, 44, 0, 0);

    // R7: flush drops in-flight work, keeps map and status
    step("R7 pre", 1, 5, 43, 20, 0, 0, 0, 0);
    step("R7 flush", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7 R8 after flush", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7 rename in flush", 1, 6, 45, 6, 0, 0, 1, 1);
    step("R7 status kept", 0, 0, 0, 0, 1, 45, 0, 0);
    step("R7 wb in flush", 0, 0, 0, 0, 1, 46, 0, 1);
    step("R7 map kept", 1, 5, 47, 5, 0, 0, 0, 0);
    step("R7 map kept retire", 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R6 idle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule